// File: doc/BRIEF.md
# Two-Port Shared Memory with Contention Arbitration

This block is a synchronous memory shared by two independent requesters, called the left side and the right side. Each side has an enable, a write select, a read enable, an address, an upper-lane select and a lower-lane select, plus its own write-data and read-data buses. Either side may read or write any word in any cycle. When both sides are enabled on the same word, an arbiter picks one of them and raises a busy flag towards the other. The side that loses cannot write, but it can still read.

A mode pin sets who drives the busy flags. In primary mode the arbiter drives them out. In follower mode the outgoing flags stay low, and busy flags that come in from a primary instance decide which writes are blocked. Several instances can therefore be placed side by side to form a wider word that is arbitrated only once.

Top module: `dpr_contention_ram`

## Requirements
- R1: A busy output is high only while both enables are high and the two addresses are equal. When the addresses differ or either enable is low, both busy outputs are low in the same cycle.
- R2: A side that already held the same enable and address in the previous cycle wins against a side that just arrived on that address. The newcomer receives busy in the cycle it arrives.
- R3: If both sides arrive on the same address in the same cycle, the left side wins and only the right side sees busy. The two busy outputs are never high together.
- R4: The winner keeps the grant for as long as its own enable and address stay unchanged. Busy to the loser drops in the first cycle in which the addresses differ or an enable is low.
- R5: With `primary_sel`=1, the busy outputs come from the arbiter and are combinational within the cycle. With `primary_sel`=0, both busy outputs are held at 0 and the `*_busy_in` pins act as the busy flags.
- R6: A side whose busy flag is active (the arbiter's flag in primary mode, the input pin in follower mode) has its write dropped. Its read still takes place.
- R7: A write changes only the lanes it selects: the upper lane is bits [15:8] and the lower lane is bits [7:0], with the default lane width of 8.
- R8: A read (enable=1, write select=0, read enable=1, at least one lane selected) returns data on `*_rdata` one clock later. Lanes that were not selected read as 0. In any cycle without a read, `*_rdata` is 0 after the next clock.
- R9: A read returns the word as it stands after the writes of the same cycle, so a read of a word that the other side writes in that cycle returns the new data. If both sides write the same lane of the same word without being blocked, the left value is stored.
- R10: A side with its enable low, or with both lane selects low, neither reads nor writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| primary_sel | input | 1 | 1: arbiter drives busy outputs; 0: busy comes from the `*_busy_in` pins |
| l_en | input | 1 | Left enable |
| l_we | input | 1 | Left write select (1 = write) |
| l_oe | input | 1 | Left read enable |
| l_ub | input | 1 | Left upper-lane select |
| l_lb | input | 1 | Left lower-lane select |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | 2*LANE_W | Left write data |
| l_rdata | output | 2*LANE_W | Left registered read data |
| l_busy_in | input | 1 | Left busy flag from a primary instance (follower mode) |
| l_busy_out | output | 1 | Left busy flag (primary mode) |
| r_en | input | 1 | Right enable |
| r_we | input | 1 | Right write select (1 = write) |
| r_oe | input | 1 | Right read enable |
| r_ub | input | 1 | Right upper-lane select |
| r_lb | input | 1 | Right lower-lane select |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | 2*LANE_W | Right write data |
| r_rdata | output | 2*LANE_W | Right registered read data |
| r_busy_in | input | 1 | Right busy flag from a primary instance (follower mode) |
| r_busy_out | output | 1 | Right busy flag (primary mode) |

## Verification
The assertions check on every cycle the properties that hold at any moment:
- busy is raised only on an address match;
- the two busy outputs are never high together;
- a held grant survives while the winner's request is unchanged;
- a side that stays in place beats a newcomer;
- both busy outputs are silent in follower mode;
- read data returns to zero after an idle cycle.

Lane merging, the blocked write, reads of words being written in the same cycle, and tie resolution when both sides write the same word are data effects. Only the bench's reference memory can show them, through the directed scenarios and a long run of random traffic confined to a few addresses.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  localparam int unsigned SIDES = 2;
endpackage

// File: rtl/dpr_arbiter.sv
module dpr_arbiter
  import dpr_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_en,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_en,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              busy_l,
  output logic              busy_r
);
  logic              prev_l_en, prev_r_en;
  logic [ADDR_W-1:0] prev_l_addr, prev_r_addr;
  owner_e            owner_q, winner;

  // Named events for the assertions
  logic addr_hit;
  logic l_held, r_held;

  assign addr_hit = l_en && r_en && (l_addr == r_addr);
  assign l_held   = prev_l_en && l_en && (prev_l_addr == l_addr);
  assign r_held   = prev_r_en && r_en && (prev_r_addr == r_addr);

  always_comb begin
    winner = OWN_NONE;
    if (addr_hit) begin
      if (owner_q == OWN_LEFT && l_held)       winner = OWN_LEFT;
      else if (owner_q == OWN_RIGHT && r_held) winner = OWN_RIGHT;
      else if (r_held && !l_held)              winner = OWN_RIGHT;
      else                                     winner = OWN_LEFT;
    end
  end

  assign busy_l = (winner == OWN_RIGHT);
  assign busy_r = (winner == OWN_LEFT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_l_en   <= 1'b0;
      prev_r_en   <= 1'b0;
      prev_l_addr <= '0;
      prev_r_addr <= '0;
      owner_q     <= OWN_NONE;
    end else begin
      prev_l_en   <= l_en;
      prev_r_en   <= r_en;
      prev_l_addr <= l_addr;
      prev_r_addr <= r_addr;
      owner_q     <= winner;
    end
  end

  // R1: busy only on a live address match
  a_r1_busy_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_l || busy_r) |-> (l_en && r_en && l_addr == r_addr));

  // R3: never two losers
  a_r3_single_loser: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_l && busy_r));

  // R2: a side that stayed in place beats a newcomer
  a_r2_first_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (l_en && r_en && l_addr == r_addr && $past(l_en) && !$past(r_en) && $stable(l_addr))
      |-> busy_r);

  // R4: left grant survives while left request is unchanged and still matching
  a_r4_grant_kept: assert property (@(posedge clk) disable iff (!rst_n)
    busy_r |=> (!(l_en && r_en && l_addr == r_addr && $stable(l_addr)) || busy_r));
endmodule

// File: rtl/dpr_port.sv
module dpr_port #(
  parameter int unsigned LANE_W = 8,
  localparam int unsigned DATA_W = 2 * LANE_W
) (
  input  logic              primary_sel,
  input  logic              en,
  input  logic              we,
  input  logic              oe,
  input  logic              ub,
  input  logic              lb,
  input  logic              busy_arb,
  input  logic              busy_in,
  output logic              busy_eff,
  output logic              wr_go,
  output logic              rd_go,
  output logic [DATA_W-1:0] lane_mask
);
  function automatic logic [DATA_W-1:0] lanes(input logic up, input logic lo);
    return {{LANE_W{up}}, {LANE_W{lo}}};
  endfunction

  logic any_lane;
  assign any_lane  = ub || lb;
  assign busy_eff  = primary_sel ? busy_arb : busy_in;
  assign wr_go     = en && we && any_lane && !busy_eff;
  assign rd_go     = en && !we && oe && any_lane;
  assign lane_mask = lanes(ub, lb);
endmodule

// File: rtl/dpr_store.sv
module dpr_store
  import dpr_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SIDES-1:0]  wr_go,
  input  logic [SIDES-1:0]  rd_go,
  input  logic [ADDR_W-1:0] addr  [SIDES],
  input  logic [DATA_W-1:0] wdata [SIDES],
  input  logic [DATA_W-1:0] mask  [SIDES],
  output logic [DATA_W-1:0] rdata [SIDES]
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] after_w [SIDES];

  function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old,
                                              input logic [DATA_W-1:0] nw,
                                              input logic [DATA_W-1:0] m);
    return (old & ~m) | (nw & m);
  endfunction

  // Word as it stands after this cycle's writes; right applied first, left last
  always_comb begin
    for (int p = 0; p < SIDES; p++) begin
      after_w[p] = mem[addr[p]];
      if (wr_go[1] && addr[1] == addr[p]) after_w[p] = merge(after_w[p], wdata[1], mask[1]);
      if (wr_go[0] && addr[0] == addr[p]) after_w[p] = merge(after_w[p], wdata[0], mask[0]);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_go[1]) mem[addr[1]] <= after_w[1];
    if (wr_go[0]) mem[addr[0]] <= after_w[0];
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < SIDES; p++) begin
      if (!rst_n)        rdata[p] <= '0;
      else if (rd_go[p]) rdata[p] <= after_w[p] & mask[p];
      else               rdata[p] <= '0;
    end
  end

  // R8: idle cycle returns read data to zero
  a_r8_idle_zero_l: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_go[0] |=> rdata[0] == '0);
  a_r8_idle_zero_r: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_go[1] |=> rdata[1] == '0);
endmodule

// File: rtl/dpr_contention_ram.sv
module dpr_contention_ram
  import dpr_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned DATA_W = 2 * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              primary_sel,
  input  logic              l_en,
  input  logic              l_we,
  input  logic              l_oe,
  input  logic              l_ub,
  input  logic              l_lb,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              l_busy_in,
  output logic              l_busy_out,
  input  logic              r_en,
  input  logic              r_we,
  input  logic              r_oe,
  input  logic              r_ub,
  input  logic              r_lb,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  input  logic              r_busy_in,
  output logic              r_busy_out
);
  logic [SIDES-1:0]  en_a, we_a, oe_a, ub_a, lb_a, bin_a, barb_a, beff_a, wr_a, rd_a;
  logic [ADDR_W-1:0] addr_a  [SIDES];
  logic [DATA_W-1:0] wdata_a [SIDES];
  logic [DATA_W-1:0] mask_a  [SIDES];
  logic [DATA_W-1:0] rdata_a [SIDES];

  assign en_a  = {r_en, l_en};
  assign we_a  = {r_we, l_we};
  assign oe_a  = {r_oe, l_oe};
  assign ub_a  = {r_ub, l_ub};
  assign lb_a  = {r_lb, l_lb};
  assign bin_a = {r_busy_in, l_busy_in};
  assign addr_a[0]  = l_addr;
  assign addr_a[1]  = r_addr;
  assign wdata_a[0] = l_wdata;
  assign wdata_a[1] = r_wdata;

  dpr_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .l_en(l_en), .l_addr(l_addr), .r_en(r_en), .r_addr(r_addr),
    .busy_l(barb_a[0]), .busy_r(barb_a[1])
  );

  for (genvar g = 0; g < SIDES; g++) begin : g_side
    dpr_port #(.LANE_W(LANE_W)) u_port (
      .primary_sel(primary_sel),
      .en(en_a[g]), .we(we_a[g]), .oe(oe_a[g]), .ub(ub_a[g]), .lb(lb_a[g]),
      .busy_arb(barb_a[g]), .busy_in(bin_a[g]), .busy_eff(beff_a[g]),
      .wr_go(wr_a[g]), .rd_go(rd_a[g]), .lane_mask(mask_a[g])
    );
  end

  dpr_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_go(wr_a), .rd_go(rd_a), .addr(addr_a), .wdata(wdata_a),
    .mask(mask_a), .rdata(rdata_a)
  );

  assign l_rdata    = rdata_a[0];
  assign r_rdata    = rdata_a[1];
  assign l_busy_out = primary_sel && barb_a[0];
  assign r_busy_out = primary_sel && barb_a[1];

  // R5: follower mode keeps both busy outputs silent
  a_r5_follower_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !primary_sel |-> (!l_busy_out && !r_busy_out));
endmodule

// File: tb/dpr_contention_ram_tb.sv
module dpr_contention_ram_tb;
  localparam int CLK_P = 10;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic primary_sel = 1'b1;
  logic en [2], we [2], oe [2], ub [2], lb [2], bin [2];
  logic [AW-1:0] addr [2];
  logic [DW-1:0] wd [2];
  logic [DW-1:0] l_rdata, r_rdata;
  logic l_busy_out, r_busy_out;

  int n_chk = 0;
  int n_err = 0;

  // reference model state
  int mem_m [DEPTH];
  int own_m = 0;
  bit pen_m [2];
  int padr_m [2];
  int exp_rd [2];

  always #(CLK_P/2) clk = ~clk;

  dpr_contention_ram u_dut (
    .clk(clk), .rst_n(rst_n), .primary_sel(primary_sel),
    .l_en(en[0]), .l_we(we[0]), .l_oe(oe[0]), .l_ub(ub[0]), .l_lb(lb[0]),
    .l_addr(addr[0]), .l_wdata(wd[0]), .l_rdata(l_rdata),
    .l_busy_in(bin[0]), .l_busy_out(l_busy_out),
    .r_en(en[1]), .r_we(we[1]), .r_oe(oe[1]), .r_ub(ub[1]), .r_lb(lb[1]),
    .r_addr(addr[1]), .r_wdata(wd[1]), .r_rdata(r_rdata),
    .r_busy_in(bin[1]), .r_busy_out(r_busy_out)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic drive(input int p, input bit e, input bit w, input bit o,
                       input bit u, input bit l, input int a, input int d);
    en[p] = e; we[p] = w; oe[p] = o; ub[p] = u; lb[p] = l;
    addr[p] = a[AW-1:0]; wd[p] = d[DW-1:0];
  endtask

  task automatic idle_all();
    drive(0, 0, 0, 0, 0, 0, 0, 0);
    drive(1, 0, 0, 0, 0, 0, 0, 0);
  endtask

  // one clock: called just after a falling edge with inputs applied
  task automatic cycle(input string tag);
    bit hit, held [2];
    int win;
    bit beff [2], wr [2], rd [2];
    int msk [2];
    #1;
    hit = en[0] && en[1] && (addr[0] == addr[1]);
    for (int p = 0; p < 2; p++) held[p] = pen_m[p] && en[p] && (padr_m[p] == int'(addr[p]));
    win = 0;
    if (hit) begin
      if (own_m == 1 && held[0]) win = 1;
      else if (own_m == 2 && held[1]) win = 2;
      else if (held[1] && !held[0]) win = 2;
      else win = 1;
    end
    chk(tag, "l_busy_out", int'(l_busy_out), (primary_sel && win == 2) ? 1 : 0);
    chk(tag, "r_busy_out", int'(r_busy_out), (primary_sel && win == 1) ? 1 : 0);
    beff[0] = primary_sel ? (win == 2) : bin[0];
    beff[1] = primary_sel ? (win == 1) : bin[1];
    for (int p = 0; p < 2; p++) begin
      msk[p] = (ub[p] ? 'hFF00 : 0) | (lb[p] ? 'h00FF : 0);
      wr[p]  = en[p] && we[p] && (ub[p] || lb[p]) && !beff[p];
      rd[p]  = en[p] && !we[p] && oe[p] && (ub[p] || lb[p]);
    end
    // right lands first, left last
    for (int p = 1; p >= 0; p--)
      if (wr[p]) mem_m[addr[p]] = (mem_m[addr[p]] & ~msk[p] & 'hFFFF) | (int'(wd[p]) & msk[p]);
    for (int p = 0; p < 2; p++) exp_rd[p] = rd[p] ? (mem_m[addr[p]] & msk[p]) : 0;
    own_m = win;
    for (int p = 0; p < 2; p++) begin pen_m[p] = en[p]; padr_m[p] = addr[p]; end
    @(posedge clk);
    #1;
    chk(tag, "l_rdata", int'(l_rdata), exp_rd[0]);
    chk(tag, "r_rdata", int'(r_rdata), exp_rd[1]);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    idle_all();
    bin[0] = 0; bin[1] = 0;
    for (int p = 0; p < 2; p++) begin pen_m[p] = 0; padr_m[p] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R8", "reset l_rdata", int'(l_rdata), 0);
    chk("R8", "reset r_rdata", int'(r_rdata), 0);
    chk("R1", "reset l_busy", int'(l_busy_out), 0);
    chk("R1", "reset r_busy", int'(r_busy_out), 0);
    #(CLK_P/2 - 1);
    @(negedge clk);

    // fill memory
    for (int i = 0; i < DEPTH; i++) begin
      drive(0, 1, 1, 0, 1, 1, i, (i * 'h0101) ^ 'h5A3C);
      drive(1, 0, 0, 0, 0, 0, 0, 0);
      cycle("R7");
    end

    // R10: no lanes or disabled means no access
    drive(0, 1, 1, 0, 0, 0, 3, 'hFFFF); drive(1, 0, 1, 1, 1, 1, 3, 'h1111); cycle("R10");
    drive(0, 1, 0, 1, 1, 1, 3, 0); drive(1, 0, 0, 0, 0, 0, 0, 0); cycle("R10");
    drive(0, 1, 0, 1, 0, 0, 3, 0); cycle("R10");

    // R7 / R8: lane writes and lane reads
    drive(0, 1, 1, 0, 1, 0, 4, 'hABCD); cycle("R7");
    drive(0, 1, 1, 0, 0, 1, 5, 'h1234); cycle("R7");
    drive(0, 1, 0, 1, 1, 1, 4, 0); drive(1, 1, 0, 1, 0, 1, 5, 0); cycle("R8");
    drive(0, 1, 0, 1, 1, 0, 5, 0); drive(1, 1, 0, 0, 1, 1, 5, 0); cycle("R8");
    idle_all(); cycle("R8");

    // R1: different addresses never busy
    drive(0, 1, 0, 1, 1, 1, 6, 0); drive(1, 1, 1, 0, 1, 1, 7, 'h7777); cycle("R1");

    // R3 / R6: same-cycle arrival, left wins, right write blocked
    idle_all(); cycle("R1");
    drive(0, 1, 0, 1, 1, 1, 10, 0); drive(1, 1, 1, 0, 1, 1, 10, 'hDEAD); cycle("R3");
    drive(1, 1, 1, 0, 1, 1, 10, 'hBEEF); cycle("R6");
    // R4: grant held, then right moves away
    drive(1, 1, 0, 1, 1, 1, 10, 0); cycle("R4");
    drive(1, 1, 0, 1, 1, 1, 11, 0); cycle("R4");
    drive(1, 1, 0, 1, 1, 1, 10, 0); cycle("R4");

    // R2: right arrives first, left joins later
    idle_all(); cycle("R2");
    drive(1, 1, 0, 1, 1, 1, 12, 0); cycle("R2");
    drive(0, 1, 1, 0, 1, 1, 12, 'hCAFE); cycle("R2");
    cycle("R6");
    // R4: winner drops enable
    drive(1, 0, 0, 0, 0, 0, 0, 0); drive(0, 1, 0, 1, 1, 1, 12, 0); cycle("R4");

    // R9: same-cycle write seen by other side's read
    drive(0, 1, 1, 0, 1, 1, 20, 'h9A9A); drive(1, 1, 0, 1, 1, 1, 20, 0); cycle("R9");
    drive(0, 1, 0, 1, 1, 1, 20, 0); drive(1, 1, 1, 0, 0, 1, 21, 'h00EE); cycle("R9");
    drive(0, 1, 0, 1, 1, 1, 21, 0); drive(1, 1, 1, 0, 1, 1, 20, 'h4455); cycle("R9");

    // R5: follower mode
    primary_sel = 0;
    idle_all(); cycle("R5");
    drive(0, 1, 1, 0, 1, 1, 22, 'h1111); drive(1, 1, 1, 0, 1, 1, 22, 'h2222); cycle("R9");
    drive(0, 1, 0, 1, 1, 1, 22, 0); drive(1, 1, 0, 1, 1, 1, 22, 0); cycle("R5");
    bin[0] = 1; drive(0, 1, 1, 0, 1, 1, 23, 'h3333); drive(1, 1, 0, 1, 1, 1, 23, 0); cycle("R6");
    bin[0] = 0; bin[1] = 1; drive(1, 1, 0, 1, 1, 1, 23, 0); drive(0, 1, 0, 1, 1, 1, 23, 0); cycle("R5");
    bin[1] = 0;
    primary_sel = 1;
    idle_all(); cycle("R5");

    // random traffic on a few addresses
    for (int n = 0; n < 4000; n++) begin
      if (n % 700 == 699) primary_sel = ~primary_sel;
      for (int p = 0; p < 2; p++) begin
        if ($urandom % 3 != 0)
          drive(p, ($urandom % 5) != 0, $urandom % 2, ($urandom % 4) != 0,
                $urandom % 2, $urandom % 2, $urandom % 4, $urandom % 65536);
        bin[p] = (($urandom % 6) == 0);
      end
      cycle("RND");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule